// File: doc/BRIEF.md
# Line-Cycle Synchronized Energy Accumulator

This block sums a stream of signed power samples over a window measured in half-line cycles instead of clock cycles. Window edges are the zero-crossing pulses of the voltage channel, so every window covers a whole number of half cycles. When a window closes, a fixed upper slice of the wide internal sum is latched into an output energy register. A sticky end-of-window status flag is set at the same moment. The next window opens in that same cycle, so no sample is lost between windows.

Software drives a small write port. It programs the half-cycle count, two control bits (absolute mode and interrupt enable), the no-load threshold used in absolute mode, and a write-one-to-clear for the status flag. Writing a new count discards the running sum and the published result. The block then waits for the next zero crossing before it opens the first window, so the first result after the write is a complete measurement. In absolute mode the block adds the magnitude of each sample and drops any sample whose magnitude is below the threshold. The running sum saturates instead of wrapping.

Top module: `line_energy_acc`

## Requirements
- R1: After reset, `rd_energy`, `eoc_flag` and `irq` are 0. The count, the threshold and both control bits are 0, so nothing accumulates until a count is written.
- R2: A write to address 0 with a non-zero count arms the block. The next zero crossing opens a window and is not counted as a half cycle. A sample that arrives in the same cycle as that opening crossing belongs to the new window.
- R3: In normal mode, every sample with `smp_vld` high adds its signed value to the running sum. The power word is ignored in cycles where `smp_vld` is low.
- R4: The window closes on the N-th zero crossing after the opening one, where N is the programmed count. One cycle later, `rd_energy` shows bits [ACC_W-1:ACC_W-OUT_W] of the sum. A sample that arrives in the same cycle as the closing crossing belongs to the next window.
- R5: Closing a window sets `eoc_flag`, and the next window starts in the same cycle with no gap.
- R6: Each closing window overwrites `rd_energy`, whether or not the previous value was read.
- R7: `rd_energy` changes only when a window closes or a count is written.
- R8: A count write clears `rd_energy` and the running sum and abandons any open window. It takes precedence over a zero crossing in the same cycle.
- R9: When the count is 0, no window opens and `eoc_flag` is never set.
- R10: Address 1 holds the control bits: bit 0 enables absolute mode and bit 1 enables the interrupt. In absolute mode each valid sample adds its magnitude, and a sample whose magnitude is below the unsigned threshold at address 2 adds nothing.
- R11: The signed running sum saturates at its largest positive value and at its most negative value instead of wrapping.
- R12: `irq` equals `eoc_flag` AND the interrupt-enable bit, and it is registered in the same cycle as the flag. Writing address 3 with bit 0 set clears the flag. If a clear and a window close fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Power sample strobe |
| smp_pwr | input | PWR_W | Signed power sample |
| zc_pulse | input | 1 | Zero-crossing event, one cycle per crossing |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 count, 1 control, 2 threshold, 3 status clear |
| wr_data | input | DATA_W | Write data |
| rd_energy | output | OUT_W | Latched energy result |
| eoc_flag | output | 1 | Sticky end-of-window status |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with 8-bit samples, a 4-bit count, a 16-bit sum and an 8-bit result. With these sizes it can sweep every non-zero count with two zero-crossing spacings and a stepped set of thresholds across the whole magnitude range. Both saturation limits are reached within a few hundred samples. It also covers a count write that lands mid-window and one that coincides with a crossing, and a status clear that coincides with a window close.

// File: rtl/lea_pkg.sv
package lea_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN} lea_state_e;
  localparam logic [1:0] A_COUNT  = 2'd0;
  localparam logic [1:0] A_CTRL   = 2'd1;
  localparam logic [1:0] A_THRESH = 2'd2;
  localparam logic [1:0] A_STATUS = 2'd3;
endpackage

// File: rtl/lea_sample_cond.sv
module lea_sample_cond #(
  parameter int PWR_W = 16,
  parameter int ACC_W = 48
) (
  input  logic             vld,
  input  logic [PWR_W-1:0] pwr,
  input  logic             abs_mode,
  input  logic [PWR_W-1:0] thr,
  output logic [ACC_W-1:0] contrib
);
  logic [PWR_W:0] ext;
  logic [PWR_W:0] mag;
  logic           pass;

  always_comb begin
    ext  = {pwr[PWR_W-1], pwr};
    mag  = ext[PWR_W] ? (PWR_W+1)'(-ext) : ext;
    pass = (mag >= {1'b0, thr});
    if (!vld)
      contrib = '0;
    else if (abs_mode)
      contrib = pass ? {{(ACC_W-PWR_W-1){1'b0}}, mag} : '0;
    else
      contrib = {{(ACC_W-PWR_W){pwr[PWR_W-1]}}, pwr};
  end
endmodule

// File: rtl/lea_window_ctl.sv
module lea_window_ctl
  import lea_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             zc,
  output logic             acc_en,
  output logic             win_end,
  output logic [CNT_W-1:0] cnt_q
);
  lea_state_e       state_q;
  logic [CNT_W-1:0] hcnt_q;

  assign acc_en  = !cnt_wr && ((state_q == ST_RUN) || (state_q == ST_ARM && zc));
  assign win_end = !cnt_wr && (state_q == ST_RUN) && zc &&
                   (hcnt_q == cnt_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      hcnt_q  <= '0;
      cnt_q   <= '0;
    end else if (cnt_wr) begin
      cnt_q   <= cnt_val;
      hcnt_q  <= '0;
      state_q <= (cnt_val == '0) ? ST_IDLE : ST_ARM;
    end else begin
      case (state_q)
        ST_ARM: if (zc) begin
          state_q <= ST_RUN;
          hcnt_q  <= '0;
        end
        ST_RUN: if (zc) hcnt_q <= win_end ? '0 : hcnt_q + CNT_W'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lea_sat_acc.sv
module lea_sat_acc #(
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             restart,
  input  logic             add_en,
  input  logic [ACC_W-1:0] contrib,
  output logic [ACC_W-1:0] acc_q
);
  localparam logic [ACC_W-1:0] MAX_V = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_V = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] base;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] sat;

  always_comb begin
    base = restart ? '0 : acc_q;
    sum  = {base[ACC_W-1], base} + {contrib[ACC_W-1], contrib};
    if (sum[ACC_W] != sum[ACC_W-1])
      sat = sum[ACC_W] ? MIN_V : MAX_V;
    else
      sat = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else if (add_en) acc_q <= sat;
  end
endmodule

// File: rtl/line_energy_acc.sv
module line_energy_acc
  import lea_pkg::*;
#(
  parameter int PWR_W  = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int ACC_W  = 48,
  parameter int OUT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [PWR_W-1:0]  smp_pwr,
  input  logic              zc_pulse,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OUT_W-1:0]  rd_energy,
  output logic              eoc_flag,
  output logic              irq
);
  localparam int OUT_LSB = ACC_W - OUT_W;

  logic             cnt_wr, ctrl_wr, thr_wr, stat_clr;
  logic             abs_q, ie_q, ie_n, flag_n;
  logic [PWR_W-1:0] thr_q;
  logic [ACC_W-1:0] contrib, acc_q;
  logic             acc_en, win_end;
  logic [CNT_W-1:0] cnt_q;

  assign cnt_wr   = wr_en && (wr_addr == A_COUNT);
  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  assign thr_wr   = wr_en && (wr_addr == A_THRESH);
  assign stat_clr = wr_en && (wr_addr == A_STATUS) && wr_data[0];

  lea_sample_cond #(.PWR_W(PWR_W), .ACC_W(ACC_W)) i_cond (
    .vld(smp_vld), .pwr(smp_pwr), .abs_mode(abs_q), .thr(thr_q), .contrib(contrib)
  );

  lea_window_ctl #(.CNT_W(CNT_W)) i_ctl (
    .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .cnt_val(wr_data[CNT_W-1:0]),
    .zc(zc_pulse), .acc_en(acc_en), .win_end(win_end), .cnt_q(cnt_q)
  );

  lea_sat_acc #(.ACC_W(ACC_W)) i_acc (
    .clk(clk), .rst(rst), .clr(cnt_wr), .restart(win_end), .add_en(acc_en),
    .contrib(contrib), .acc_q(acc_q)
  );

  assign flag_n = win_end ? 1'b1 : (stat_clr ? 1'b0 : eoc_flag);
  assign ie_n   = ctrl_wr ? wr_data[1] : ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      abs_q     <= 1'b0;
      ie_q      <= 1'b0;
      thr_q     <= '0;
      rd_energy <= '0;
      eoc_flag  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (ctrl_wr) abs_q <= wr_data[0];
      ie_q <= ie_n;
      if (thr_wr) thr_q <= wr_data[PWR_W-1:0];
      if (cnt_wr) rd_energy <= '0;
      else if (win_end) rd_energy <= acc_q[OUT_LSB +: OUT_W];
      eoc_flag <= flag_n;
      irq      <= flag_n & ie_n;
    end
  end
endmodule

// File: rtl/lea_checker.sv
module lea_checker #(
  parameter int CNT_W = 16,
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_wr,
  input logic             win_end,
  input logic             stat_clr,
  input logic [CNT_W-1:0] cnt_q,
  input logic [OUT_W-1:0] rd_energy,
  input logic             eoc_flag,
  input logic             irq
);
  a_r12_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> eoc_flag);
  a_r7_result_moves_on_event: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_energy) |-> $past(win_end || cnt_wr));
  a_r8_write_clears_result: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (rd_energy == '0));
  a_r5_flag_on_close: assert property (@(posedge clk) disable iff (rst)
    win_end |=> eoc_flag);
  a_r9_zero_count_quiet: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |-> !win_end);
  a_r12_clear_drops_flag: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !win_end) |=> !eoc_flag);
endmodule

bind line_energy_acc lea_checker #(.CNT_W(CNT_W), .OUT_W(OUT_W)) i_chk (
  .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .win_end(win_end), .stat_clr(stat_clr),
  .cnt_q(cnt_q), .rd_energy(rd_energy), .eoc_flag(eoc_flag), .irq(irq)
);

// File: tb/test_line_energy_acc.sv
module test_line_energy_acc;
  localparam int PWR_W = 8, DATA_W = 8, CNT_W = 4, ACC_W = 16, OUT_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst = 1'b1, smp_vld = 1'b0, zc_pulse = 1'b0, wr_en = 1'b0;
  logic [PWR_W-1:0]  smp_pwr = '0;
  logic [1:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [OUT_W-1:0]  rd_energy;
  logic              eoc_flag, irq;

  line_energy_acc #(.PWR_W(PWR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                    .ACC_W(ACC_W), .OUT_W(OUT_W)) i_line_energy_acc (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_pwr(smp_pwr), .zc_pulse(zc_pulse),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_energy(rd_energy), .eoc_flag(eoc_flag), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  longint m_acc, m_res, m_thr, m_cnt, m_h;
  int  m_state;
  bit  m_flag, m_ie, m_abs, m_irq;

  function automatic longint sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_res = 0; m_thr = 0; m_cnt = 0; m_h = 0; m_state = 0;
    m_flag = 0; m_ie = 0; m_abs = 0; m_irq = 0;
  endtask

  task automatic tick(input string tag);
    longint c, p, mag;
    bit endw;
    @(posedge clk);
    p = longint'($signed(smp_pwr));
    mag = (p < 0) ? -p : p;
    if (!smp_vld) c = 0;
    else if (m_abs) c = (mag >= m_thr) ? mag : 0;
    else c = p;
    endw = 0;
    if (wr_en && wr_addr == 2'd0) begin
      m_cnt = longint'(wr_data[CNT_W-1:0]); m_acc = 0; m_res = 0; m_h = 0;
      m_state = (m_cnt == 0) ? 0 : 1;
    end else if (m_state == 1) begin
      if (zc_pulse) begin m_state = 2; m_h = 0; m_acc = sat(m_acc + c); end
    end else if (m_state == 2) begin
      if (zc_pulse && m_h == m_cnt - 1) begin
        m_res = (m_acc >>> 8) & 255; m_acc = sat(c); m_h = 0; endw = 1;
      end else begin
        if (zc_pulse) m_h++;
        m_acc = sat(m_acc + c);
      end
    end
    if (wr_en && wr_addr == 2'd1) begin m_abs = wr_data[0]; m_ie = wr_data[1]; end
    if (wr_en && wr_addr == 2'd2) m_thr = longint'(wr_data);
    if (endw) m_flag = 1;
    else if (wr_en && wr_addr == 2'd3 && wr_data[0]) m_flag = 0;
    m_irq = m_flag & m_ie;
    @(negedge clk);
    chk(tag, {irq, eoc_flag, rd_energy}, {m_irq, m_flag, m_res[7:0]});
  endtask

  task automatic wr(input logic [1:0] a, input int d, input bit zc, input string tag);
    wr_en = 1; wr_addr = a; wr_data = DATA_W'(d); zc_pulse = zc;
    tick(tag);
    wr_en = 0; zc_pulse = 0;
  endtask

  task automatic run(input int n, input int per, input int kind, input bit clr_zc,
                     input string tag);
    for (int i = 0; i < n; i++) begin
      zc_pulse = ((i % per) == per - 1);
      smp_vld  = ((i % 5) != 3);
      case (kind)
        0: smp_pwr = PWR_W'((i * 37 + 13) % 256);
        1: smp_pwr = 8'h7f;
        default: smp_pwr = 8'h80;
      endcase
      wr_en = clr_zc && zc_pulse; wr_addr = 2'd3; wr_data = 8'd1;
      tick(tag);
    end
    zc_pulse = 0; smp_vld = 0; wr_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    if (!done) begin done = 1; $display("CHECKS %0d ERRORS %0d", checks, errors); end
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {irq, eoc_flag, rd_energy}, 10'd0);
    rst = 0;
    run(20, 3, 0, 0, "R1 idle after reset");
    // R2 R3 R4 R5 R6: sweep every count with two crossing spacings
    for (int c = 1; c < 16; c++)
      for (int per = 3; per <= 4; per++) begin
        wr(2'd0, c, 1'b0, "R2 count write");
        run(c * per * 2 + per + 2, per, 0, 0, "R3 R4 R5 R6 window sweep");
      end
    // R8: mid-window rewrite, and rewrite coincident with a crossing
    wr(2'd0, 5, 1'b0, "R8");
    run(7, 3, 0, 0, "R8 partial");
    wr(2'd0, 2, 1'b1, "R8 write with crossing");
    run(25, 3, 0, 0, "R8 R7 after rewrite");
    // R9: zero count
    wr(2'd3, 1, 1'b0, "R9 clear");
    wr(2'd0, 0, 1'b0, "R9 zero count");
    run(60, 3, 0, 0, "R9 zero count");
    chk("R9 flag stays low", eoc_flag, 0);
    // R10: absolute mode threshold sweep
    wr(2'd1, 1, 1'b0, "R10 abs on");
    for (int t = 0; t < 256; t += 15) begin
      wr(2'd2, t, 1'b0, "R10 thr");
      wr(2'd0, 3, 1'b0, "R10 count");
      run(20, 4, 0, 0, "R10 abs window");
    end
    run(30, 4, 2, 0, "R10 abs most negative");
    // R11: saturation both ways
    wr(2'd1, 0, 1'b0, "R11 abs off");
    wr(2'd0, 15, 1'b0, "R11 count");
    run(15 * 40 + 45, 40, 1, 0, "R11 positive");
    chk("R11 positive limit", rd_energy, 8'h7f);
    wr(2'd0, 15, 1'b0, "R11 count");
    run(15 * 40 + 45, 40, 2, 0, "R11 negative");
    chk("R11 negative limit", rd_energy, 8'h80);
    // R12: interrupt, clear colliding with close, plain clear
    wr(2'd1, 2, 1'b0, "R12 enable");
    wr(2'd0, 1, 1'b0, "R12 count");
    run(22, 4, 0, 1, "R12 set wins over clear");
    chk("R12 flag kept", eoc_flag, 1);
    chk("R12 irq high", irq, 1);
    wr(2'd3, 1, 1'b0, "R12 clear");
    chk("R12 flag cleared", eoc_flag, 0);
    chk("R12 irq cleared", irq, 0);
    run(9, 4, 0, 0, "R12 irq returns");
    wr(2'd1, 0, 1'b0, "R12 disable masks irq");
    chk("R12 irq masked", irq, 0);
    if (!done) begin done = 1; $display("CHECKS %0d ERRORS %0d", checks, errors); end
    $finish;
  end
endmodule